// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns a one-cycle host request into the complete strobe sequence an 8-bit multiplexed NAND flash part expects. The host names an operation and supplies a row address, a column address and a byte count. The block then does the rest. It pulls chip enable low and frames every byte with the command-latch or address-latch line. It pulses write enable or read enable with clock-counted setup, pulse and hold windows. It also waits on the synchronised ready/busy line.

Write data is pulled from the host one byte at a time through an acknowledge pulse. Read data is pushed back with a valid pulse. A program or an erase ends with an automatic status read, and bit 0 of that status is reported as the fail flag. Every busy wait is guarded by a watchdog whose limit comes from an input. When the limit expires, the operation is abandoned and a timeout is flagged.

Top module: `nand_seq`

## Requirements
- R1: After reset, and whenever no operation is in progress, ce_no, we_no and re_no are high, cle_o, ale_o and io_oe_o are low, and busy_o is low.
- R2: A page read (op_i=0) sends command 00h, then five address bytes in this order: column low, column high, row bits 7:0, row bits 15:8, row bits 23:16. It then sends command 30h. It waits for rb_i to fall and rise, and then reads len_i bytes with re_no, each presented once on rdata_o with rdata_vld_o.
- R3: A page program (op_i=1) sends 80h, the same five address bytes, len_i data bytes taken from wdata_i (each consumed with a wdata_ack_o pulse), and confirm 10h. It then waits for ready, sends 70h and reads one status byte. fail_o then equals bit 0 of that byte.
- R4: A block erase (op_i=2) sends 60h, the three row bytes (low first) and confirm D0h. It then waits for ready and reads status as in R3.
- R5: Reset (op_i=3) sends FFh and waits for ready. Read status (op_i=4) sends 70h and returns one byte on rdata_o. Read ID (op_i=5) sends 90h and one address byte 00h, and then reads len_i bytes.
- R6: A byte latched by a rising we_no has cle_o high for a command, ale_o high for an address, and both low for data. The two lines are never high together.
- R7: we_no stays low for at least T_PW clocks. While it is low, io_o, cle_o and ale_o do not change. we_no and re_no are never low together.
- R8: In a program, at least T_ADL clocks pass between the rising we_no of the last address byte and the falling we_no of the first data byte.
- R9: If a busy wait lasts wdog_limit_i clocks, the operation ends at once with done_o and timeout_o high. No status command is sent, and ce_no returns high.
- R10: req_i is ignored while busy_o is high. No extra bus cycle follows from it.
- R11: io_oe_o is low whenever re_no is low.
- R12: done_o is a single-cycle pulse at the end of every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start pulse, sampled while idle |
| op_i | input | 3 | Operation code (see R2-R5) |
| row_i | input | 24 | Row (page/block) address |
| col_i | input | 16 | Column address |
| len_i | input | LEN_W | Number of data bytes to write or read |
| wdog_limit_i | input | WD_W | Busy-wait limit in clocks |
| wdata_i | input | 8 | Current write byte |
| wdata_ack_o | output | 1 | Write byte consumed |
| rdata_o | output | 8 | Read byte |
| rdata_vld_o | output | 1 | rdata_o valid |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation finished (pulse) |
| fail_o | output | 1 | Status bit 0 from last program/erase |
| timeout_o | output | 1 | Last operation aborted by watchdog |
| ce_no | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write enable, active low |
| re_no | output | 1 | Read enable, active low |
| io_o | output | 8 | I/O bus drive value |
| io_oe_o | output | 1 | I/O bus output enable |
| io_i | input | 8 | I/O bus sampled value |
| rb_i | input | 1 | Ready/busy line (low = busy) |

## Verification
Each bus byte comes due at the rising edge of its strobe. The bench model therefore latches command, address and data bytes on the rising edge of we_no. It measures pulse width and the address-to-data gap against that edge in clock periods. It places read data on the falling edge of re_no, a full pulse width before the block samples it on the last clock of the low phase. Read and status results are collected on the clock where rdata_vld_o is high. The whole log, fail_o and timeout_o are compared only after done_o is seen at a falling clock edge, by which point every strobe of the operation has completed. Busy time and the busy onset delay are set by the bench model. The timeout case deliberately holds busy past wdog_limit_i.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    OP_READ = 3'd0, OP_PROG = 3'd1, OP_ERASE = 3'd2,
    OP_RESET = 3'd3, OP_STATUS = 3'd4, OP_ID = 3'd5
  } op_e;

  typedef enum logic [1:0] {BK_CMD, BK_ADDR, BK_WR, BK_RD} bus_kind_e;

  localparam logic [7:0] OPC_STATUS = 8'h70;

  function automatic logic [7:0] lead_opc(op_e op);
    case (op)
      OP_READ:   return 8'h00;
      OP_PROG:   return 8'h80;
      OP_ERASE:  return 8'h60;
      OP_RESET:  return 8'hFF;
      OP_STATUS: return OPC_STATUS;
      default:   return 8'h90;
    endcase
  endfunction

  function automatic logic [7:0] confirm_opc(op_e op);
    case (op)
      OP_READ: return 8'h30;
      OP_PROG: return 8'h10;
      default: return 8'hD0;
    endcase
  endfunction

  function automatic int addr_cycles(op_e op);
    case (op)
      OP_READ, OP_PROG: return 5;
      OP_ERASE:         return 3;
      default:          return 1;
    endcase
  endfunction
endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_seq_pkg::*;
#(
  parameter int T_SU = 1,
  parameter int T_PW = 2,
  parameter int T_HD = 1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  bus_kind_e kind_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] io_i,
  output logic      cle_o,
  output logic      ale_o,
  output logic      we_no,
  output logic      re_no,
  output logic      io_oe_o,
  output logic [7:0] io_o,
  output logic [7:0] rbyte_o,
  output logic      done_o
);
  localparam int TMAX = (T_SU > T_PW) ? ((T_SU > T_HD) ? T_SU : T_HD)
                                      : ((T_PW > T_HD) ? T_PW : T_HD);
  localparam int CW = $clog2(TMAX + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SU, PH_PW, PH_HD} ph_e;

  ph_e       ph_q;
  logic [CW-1:0] cnt_q;
  bus_kind_e kind_q;
  logic [7:0] byte_q, rbyte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      kind_q  <= BK_CMD;
      byte_q  <= '0;
      rbyte_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q   <= PH_SU;
          cnt_q  <= CW'(T_SU - 1);
          kind_q <= kind_i;
          byte_q <= byte_i;
        end
        PH_SU: if (cnt_q == '0) begin
          ph_q  <= PH_PW;
          cnt_q <= CW'(T_PW - 1);
        end else cnt_q <= cnt_q - 1'b1;
        PH_PW: if (cnt_q == '0) begin
          ph_q  <= PH_HD;
          cnt_q <= CW'(T_HD - 1);
          if (kind_q == BK_RD) rbyte_q <= io_i;
        end else cnt_q <= cnt_q - 1'b1;
        default: if (cnt_q == '0) ph_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  wire act = (ph_q != PH_IDLE);
  assign cle_o   = act && (kind_q == BK_CMD);
  assign ale_o   = act && (kind_q == BK_ADDR);
  assign io_oe_o = act && (kind_q != BK_RD);
  assign we_no   = !((ph_q == PH_PW) && (kind_q != BK_RD));
  assign re_no   = !((ph_q == PH_PW) && (kind_q == BK_RD));
  assign io_o    = byte_q;
  assign rbyte_o = rbyte_q;
  assign done_o  = (ph_q == PH_HD) && (cnt_q == '0);
endmodule

// File: rtl/nand_rb_wait.sv
module nand_rb_wait #(
  parameter int WD_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            rb_i,
  input  logic [WD_W-1:0] limit_i,
  output logic            done_o,
  output logic            tmo_o
);
  typedef enum logic [1:0] {W_IDLE, W_LOW, W_HIGH} wph_e;

  wph_e            ph_q;
  logic [WD_W-1:0] cnt_q;
  logic [1:0]      rb_s;

  wire rb    = rb_s[1];
  wire limit = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rb_s <= 2'b11;
    else         rb_s <= {rb_s[0], rb_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= W_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        W_IDLE: if (start_i) begin
          ph_q  <= W_LOW;
          cnt_q <= '0;
        end
        W_LOW: begin
          cnt_q <= cnt_q + 1'b1;
          if (limit)   ph_q <= W_IDLE;
          else if (!rb) ph_q <= W_HIGH;
        end
        default: begin
          cnt_q <= cnt_q + 1'b1;
          if (limit || rb) ph_q <= W_IDLE;
        end
      endcase
    end
  end

  assign tmo_o  = (ph_q != W_IDLE) && limit;
  assign done_o = (ph_q == W_HIGH) && rb && !limit;
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int T_SU  = 1,
  parameter int T_PW  = 2,
  parameter int T_HD  = 1,
  parameter int T_ADL = 3,
  parameter int LEN_W = 12,
  parameter int WD_W  = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       op_i,
  input  logic [23:0]      row_i,
  input  logic [15:0]      col_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [WD_W-1:0]  wdog_limit_i,
  input  logic [7:0]       wdata_i,
  output logic             wdata_ack_o,
  output logic [7:0]       rdata_o,
  output logic             rdata_vld_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic             timeout_o,
  output logic             ce_no,
  output logic             cle_o,
  output logic             ale_o,
  output logic             we_no,
  output logic             re_no,
  output logic [7:0]       io_o,
  output logic             io_oe_o,
  input  logic [7:0]       io_i,
  input  logic             rb_i
);
  localparam int AW = $clog2(T_ADL + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_ADL, S_WDATA,
    S_WAIT, S_STCMD, S_STRD, S_RDATA, S_FIN
  } st_e;

  st_e              st_q;
  op_e              op_q;
  logic [23:0]      row_q;
  logic [15:0]      col_q;
  logic [LEN_W-1:0] len_q, idx_q;
  logic [AW-1:0]    adl_q;
  logic             launched_q, fail_q, tmo_q;

  logic       cyc_start, cyc_done, wait_start, wait_done, wait_tmo;
  bus_kind_e  cyc_kind;
  logic [7:0] cyc_byte, addr_byte, cyc_rbyte;
  logic [2:0] aidx;

  wire last_data = (idx_q == len_q - LEN_W'(1));
  wire last_addr = (idx_q == LEN_W'(addr_cycles(op_q) - 1));
  wire len_zero  = (len_q == '0);

  always_comb begin
    aidx = (op_q == OP_ERASE) ? idx_q[2:0] + 3'd2 : idx_q[2:0];
    case (aidx)
      3'd0:    addr_byte = col_q[7:0];
      3'd1:    addr_byte = col_q[15:8];
      3'd2:    addr_byte = row_q[7:0];
      3'd3:    addr_byte = row_q[15:8];
      default: addr_byte = row_q[23:16];
    endcase
    if (op_q == OP_ID) addr_byte = 8'h00;
  end

  always_comb begin
    cyc_kind = BK_RD;
    cyc_byte = 8'h00;
    case (st_q)
      S_CMD1:  begin cyc_kind = BK_CMD;  cyc_byte = lead_opc(op_q);    end
      S_ADDR:  begin cyc_kind = BK_ADDR; cyc_byte = addr_byte;         end
      S_CMD2:  begin cyc_kind = BK_CMD;  cyc_byte = confirm_opc(op_q); end
      S_WDATA: begin cyc_kind = BK_WR;   cyc_byte = wdata_i;           end
      S_STCMD: begin cyc_kind = BK_CMD;  cyc_byte = OPC_STATUS;        end
      default: ;
    endcase
  end

  wire issuing = st_q inside {S_CMD1, S_ADDR, S_CMD2, S_WDATA, S_STCMD, S_STRD, S_RDATA};
  assign cyc_start  = issuing && !launched_q;
  assign wait_start = (st_q == S_WAIT) && !launched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; op_q <= OP_READ; row_q <= '0; col_q <= '0;
      len_q <= '0; idx_q <= '0; adl_q <= '0;
      launched_q <= 1'b0; fail_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      if (cyc_start || wait_start) launched_q <= 1'b1;
      case (st_q)
        S_IDLE: if (req_i) begin
          op_q <= op_e'(op_i); row_q <= row_i; col_q <= col_i; len_q <= len_i;
          fail_q <= 1'b0; tmo_q <= 1'b0; idx_q <= '0; launched_q <= 1'b0;
          st_q <= S_CMD1;
        end
        S_CMD1: if (cyc_done) begin
          launched_q <= 1'b0;
          idx_q <= '0;
          case (op_q)
            OP_RESET:  st_q <= S_WAIT;
            OP_STATUS: st_q <= S_STRD;
            default:   st_q <= S_ADDR;
          endcase
        end
        S_ADDR: if (cyc_done) begin
          launched_q <= 1'b0;
          if (last_addr) begin
            idx_q <= '0;
            adl_q <= '0;
            case (op_q)
              OP_PROG: st_q <= S_ADL;
              OP_ID:   st_q <= len_zero ? S_FIN : S_RDATA;
              default: st_q <= S_CMD2;
            endcase
          end else idx_q <= idx_q + 1'b1;
        end
        S_ADL: if (adl_q == AW'(T_ADL - 1)) st_q <= len_zero ? S_CMD2 : S_WDATA;
               else adl_q <= adl_q + 1'b1;
        S_WDATA: if (cyc_done) begin
          launched_q <= 1'b0;
          if (last_data) st_q <= S_CMD2;
          else idx_q <= idx_q + 1'b1;
        end
        S_CMD2: if (cyc_done) begin launched_q <= 1'b0; st_q <= S_WAIT; end
        S_WAIT: if (wait_tmo) begin
          tmo_q <= 1'b1;
          st_q  <= S_FIN;
        end else if (wait_done) begin
          launched_q <= 1'b0;
          idx_q <= '0;
          case (op_q)
            OP_READ:           st_q <= len_zero ? S_FIN : S_RDATA;
            OP_PROG, OP_ERASE: st_q <= S_STCMD;
            default:           st_q <= S_FIN;
          endcase
        end
        S_STCMD: if (cyc_done) begin launched_q <= 1'b0; st_q <= S_STRD; end
        S_STRD: if (cyc_done) begin
          if (op_q != OP_STATUS) fail_q <= cyc_rbyte[0];
          st_q <= S_FIN;
        end
        S_RDATA: if (cyc_done) begin
          launched_q <= 1'b0;
          if (last_data) st_q <= S_FIN;
          else idx_q <= idx_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  nand_bus_cycle #(.T_SU(T_SU), .T_PW(T_PW), .T_HD(T_HD)) u_cyc (
    .clk_i, .rst_ni,
    .start_i (cyc_start),
    .kind_i  (cyc_kind),
    .byte_i  (cyc_byte),
    .io_i,
    .cle_o, .ale_o, .we_no, .re_no, .io_oe_o, .io_o,
    .rbyte_o (cyc_rbyte),
    .done_o  (cyc_done)
  );

  nand_rb_wait #(.WD_W(WD_W)) u_wait (
    .clk_i, .rst_ni,
    .start_i (wait_start),
    .rb_i,
    .limit_i (wdog_limit_i),
    .done_o  (wait_done),
    .tmo_o   (wait_tmo)
  );

  assign ce_no       = (st_q == S_IDLE);
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_FIN);
  assign fail_o      = fail_q;
  assign timeout_o   = tmo_q;
  assign wdata_ack_o = (st_q == S_WDATA) && cyc_done;
  assign rdata_vld_o = cyc_done && ((st_q == S_RDATA) || (st_q == S_STRD && op_q == OP_STATUS));
  assign rdata_o     = cyc_rbyte;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk #(
  parameter int T_PW  = 2,
  parameter int T_ADL = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_no,
  input logic       cle_o,
  input logic       ale_o,
  input logic       we_no,
  input logic       re_no,
  input logic       io_oe_o,
  input logic [7:0] io_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       timeout_o
);
  logic [15:0] we_lo_q, gap_q;
  logic        we_q, after_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_q <= '0; gap_q <= '0; we_q <= 1'b1; after_addr_q <= 1'b0;
    end else begin
      we_q <= we_no;
      if (!we_no) we_lo_q <= (we_lo_q == 16'hFFFF) ? we_lo_q : we_lo_q + 1'b1;
      else        we_lo_q <= '0;
      if (we_no && !we_q) begin
        after_addr_q <= ale_o;
        gap_q <= '0;
      end else if (gap_q != 16'hFFFF) gap_q <= gap_q + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ce_no && we_no && re_no && !io_oe_o && !cle_o && !ale_o)); // R1
  AST_LATCH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o)); // R6
  AST_WE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> (we_lo_q >= 16'(T_PW))); // R7
  AST_BUS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no && $past(!we_no)) |-> ($stable(io_o) && $stable(cle_o) && $stable(ale_o))); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no)); // R7
  AST_ADL_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(we_no) && !cle_o && !ale_o && after_addr_q) |-> (gap_q >= 16'(T_ADL))); // R8
  AST_TMO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o); // R9
  AST_NO_DRIVE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !io_oe_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12
endmodule

bind nand_seq nand_seq_chk #(.T_PW(T_PW), .T_ADL(T_ADL)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_no(ce_no), .cle_o(cle_o), .ale_o(ale_o),
  .we_no(we_no), .re_no(re_no), .io_oe_o(io_oe_o), .io_o(io_o),
  .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
);

// File: tb/tb_nand_seq.sv
`timescale 1ns/1ps
module tb_nand_seq;
  localparam int T_SU = 1, T_PW = 2, T_HD = 1, T_ADL = 3, LEN_W = 12, WD_W = 20;
  localparam int CLK_NS = 5;

  logic clk = 1'b0, rst_ni = 1'b0, req = 1'b0;
  logic [2:0] op = '0;
  logic [23:0] row = '0;
  logic [15:0] col = '0;
  logic [LEN_W-1:0] len = '0;
  logic [WD_W-1:0] wlim = 20'd5000;
  logic [7:0] wdata, rdata, io_o, io_in = 8'h00;
  logic wack, rvld, busy, done, fail, tmo, ce_no, cle, ale, we_no, re_no, io_oe;
  logic rb = 1'b1;

  always #(CLK_NS / 2.0) clk = ~clk;

  nand_seq #(.T_SU(T_SU), .T_PW(T_PW), .T_HD(T_HD), .T_ADL(T_ADL), .LEN_W(LEN_W), .WD_W(WD_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .op_i(op), .row_i(row), .col_i(col),
    .len_i(len), .wdog_limit_i(wlim), .wdata_i(wdata), .wdata_ack_o(wack),
    .rdata_o(rdata), .rdata_vld_o(rvld), .busy_o(busy), .done_o(done), .fail_o(fail),
    .timeout_o(tmo), .ce_no(ce_no), .cle_o(cle), .ale_o(ale), .we_no(we_no), .re_no(re_no),
    .io_o(io_o), .io_oe_o(io_oe), .io_i(io_in), .rb_i(rb)
  );

  int checks = 0, errors = 0;
  int we_chk = 0, we_err = 0, fe_chk = 0, fe_err = 0, re_chk = 0, re_err = 0;

  // flash model state
  int log_n = 0, conf_cnt = 0, conf_seen = 0, dly = 0, bcnt = 0, busy_len = 20;
  int re_rises = 0, rd_base = 0, rn = 0, widx = 0, wb0 = 0;
  logic [1:0] logk [0:1023];
  logic [7:0] logb [0:1023];
  logic [7:0] rbuf [0:1023];
  logic [7:0] wbuf [0:63];
  logic [7:0] last_cmd = 8'h00;
  logic fail_m = 1'b0, prev_addr = 1'b0;
  time t_wfall = 0, t_addr = 0;

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 17);
  endfunction

  assign wdata = wbuf[6'(widx - wb0)];

  always @(posedge we_no) if (ce_no === 1'b0) begin
    logk[log_n] = {ale, cle};
    logb[log_n] = io_o;
    log_n = log_n + 1;
    we_chk++;
    if (cle && ale) begin
      we_err++; $display("FAIL R6 both latch lines high: act=11 exp=one of them");
    end
    we_chk++;
    if (($time - t_wfall) < T_PW * CLK_NS) begin
      we_err++; $display("FAIL R7 we_no low width act=%0t exp>=%0d ns", $time - t_wfall, T_PW * CLK_NS);
    end
    if (cle) begin
      last_cmd = io_o;
      rd_base  = re_rises;
      if (io_o == 8'h30 || io_o == 8'h10 || io_o == 8'hD0 || io_o == 8'hFF) conf_cnt++;
    end
    prev_addr = ale;
    t_addr = $time;
  end

  always @(negedge we_no) if (ce_no === 1'b0) begin
    t_wfall = $time;
    if (!cle && !ale && prev_addr) begin
      fe_chk++;
      if (($time - t_addr) < T_ADL * CLK_NS) begin
        fe_err++; $display("FAIL R8 address-to-data gap act=%0t exp>=%0d ns", $time - t_addr, T_ADL * CLK_NS);
      end
    end
  end

  always @(negedge re_no) if (ce_no === 1'b0) begin
    re_chk++;
    if (io_oe !== 1'b0) begin
      re_err++; $display("FAIL R11 io_oe_o during read act=%b exp=0", io_oe);
    end
    if (last_cmd == 8'h70)      io_in = 8'h40 | {7'd0, fail_m};
    else if (last_cmd == 8'h90) io_in = 8'hC0 + 8'(re_rises - rd_base);
    else                        io_in = pat(re_rises - rd_base);
  end

  always @(posedge re_no) if (ce_no === 1'b0) re_rises++;

  always @(posedge clk) begin
    if (rvld) begin rbuf[rn] <= rdata; rn <= rn + 1; end
    if (wack) widx <= widx + 1;
    if (conf_cnt != conf_seen) begin
      conf_seen <= conf_cnt; dly <= 3;
    end else if (dly > 0) begin
      dly <= dly - 1;
      if (dly == 1) begin rb <= 1'b0; bcnt <= busy_len; end
    end else if (bcnt > 0) begin
      bcnt <= bcnt - 1;
      if (bcnt == 1) rb <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // kind: 1 command, 2 address, 0 data
  task automatic chk_ent(input int pos, input int k, input logic [7:0] b, input string tag);
    chk(logk[pos] == 2'(k) && logb[pos] == b, tag, {22'd0, logk[pos], logb[pos]}, (k << 8) | b);
  endtask

  task automatic run_op(input int o, input logic [23:0] r, input logic [15:0] c, input int n,
                        input bit poke, output int lb, output int rb0);
    @(negedge clk);
    lb = log_n; rb0 = rn; wb0 = widx;
    op = 3'(o); row = r; col = c; len = LEN_W'(n); req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      op = 3'd4; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  task automatic chk_op(input int o, input logic [23:0] r, input logic [15:0] c, input int n,
                        input int lb, input int rb0);
    int p = lb;
    case (o)
      0: begin
        chk_ent(p, 1, 8'h00, "R2 read opcode"); p++;
        chk_ent(p, 2, c[7:0], "R2 col lo"); p++;
        chk_ent(p, 2, c[15:8], "R2 col hi"); p++;
        chk_ent(p, 2, r[7:0], "R2 row0"); p++;
        chk_ent(p, 2, r[15:8], "R2 row1"); p++;
        chk_ent(p, 2, r[23:16], "R2 row2"); p++;
        chk_ent(p, 1, 8'h30, "R2 confirm"); p++;
        chk(rn - rb0 == n, "R2 read count", rn - rb0, n);
        for (int i = 0; i < n; i++) chk(rbuf[rb0 + i] == pat(i), "R2 read byte", rbuf[rb0 + i], pat(i));
      end
      1: begin
        chk_ent(p, 1, 8'h80, "R3 program opcode"); p++;
        chk_ent(p, 2, c[7:0], "R3 col lo"); p++;
        chk_ent(p, 2, c[15:8], "R3 col hi"); p++;
        chk_ent(p, 2, r[7:0], "R3 row0"); p++;
        chk_ent(p, 2, r[15:8], "R3 row1"); p++;
        chk_ent(p, 2, r[23:16], "R3 row2"); p++;
        for (int i = 0; i < n; i++) begin chk_ent(p, 0, wbuf[i], "R3 data byte"); p++; end
        chk_ent(p, 1, 8'h10, "R3 confirm"); p++;
        chk_ent(p, 1, 8'h70, "R3 status opcode"); p++;
        chk(fail == fail_m, "R3 fail bit", fail, fail_m);
      end
      default: begin
        chk_ent(p, 1, 8'h60, "R4 erase opcode"); p++;
        chk_ent(p, 2, r[7:0], "R4 row0"); p++;
        chk_ent(p, 2, r[15:8], "R4 row1"); p++;
        chk_ent(p, 2, r[23:16], "R4 row2"); p++;
        chk_ent(p, 1, 8'hD0, "R4 confirm"); p++;
        chk_ent(p, 1, 8'h70, "R4 status opcode"); p++;
        chk(fail == fail_m, "R4 fail bit", fail, fail_m);
      end
    endcase
    chk(log_n == p, "R6 bus cycle count", log_n - lb, p - lb);
    chk(tmo == 1'b0, "R9 no timeout", tmo, 0);
  endtask

  task automatic run_tests();
    int lb, rb0, o, n;
    logic [23:0] r;
    logic [15:0] c;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) wbuf[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    chk(ce_no && we_no && re_no && !cle && !ale && !io_oe && !busy && !done, "R1 reset state",
        {ce_no, we_no, re_no, cle, ale, io_oe, busy, done}, 8'b1110_0000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(ce_no && we_no && re_no && !busy, "R1 idle after reset", {ce_no, we_no, re_no, busy}, 4'b1110);

    fail_m = 1'b1;
    run_op(4, 0, 0, 0, 0, lb, rb0);
    chk_ent(lb, 1, 8'h70, "R5 status opcode");
    chk(rn - rb0 == 1 && rbuf[rb0] == 8'h41, "R5 status byte", rbuf[rb0], 8'h41);
    @(negedge clk);
    chk(!done && !busy && ce_no, "R12 done single pulse", {done, busy, ce_no}, 3'b001);

    run_op(3, 0, 0, 0, 0, lb, rb0);
    chk_ent(lb, 1, 8'hFF, "R5 reset opcode");
    chk(log_n - lb == 1 && !tmo, "R5 reset waits ready", log_n - lb, 1);

    run_op(5, 0, 0, 4, 0, lb, rb0);
    chk_ent(lb, 1, 8'h90, "R5 id opcode");
    chk_ent(lb + 1, 2, 8'h00, "R5 id address");
    for (int i = 0; i < 4; i++) chk(rbuf[rb0 + i] == 8'hC0 + 8'(i), "R5 id byte", rbuf[rb0 + i], 8'hC0 + i);

    run_op(0, 24'h00FFC0, 16'h083F, 3, 0, lb, rb0);
    chk_op(0, 24'h00FFC0, 16'h083F, 3, lb, rb0);

    fail_m = 1'b0;
    run_op(1, 24'h03A5C1, 16'h0000, 5, 0, lb, rb0);
    chk_op(1, 24'h03A5C1, 16'h0000, 5, lb, rb0);
    fail_m = 1'b1;
    run_op(1, 24'h000040, 16'h0800, 1, 0, lb, rb0);
    chk_op(1, 24'h000040, 16'h0800, 1, lb, rb0);
    run_op(2, 24'h01FFC0, 16'h0000, 0, 0, lb, rb0);
    chk_op(2, 24'h01FFC0, 16'h0000, 0, lb, rb0);

    // R10: request during a read is dropped
    run_op(0, 24'h000123, 16'h0010, 2, 1, lb, rb0);
    chk_op(0, 24'h000123, 16'h0010, 2, lb, rb0);
    repeat (30) @(negedge clk);
    chk(log_n == lb + 7 && !busy, "R10 request while busy ignored", log_n - lb, 7);

    for (int k = 0; k < 8; k++) begin
      o = $urandom_range(0, 2);
      r = 24'($urandom);
      c = 16'($urandom_range(0, 2111));
      n = $urandom_range(1, 6);
      fail_m = 1'($urandom);
      run_op(o, r, c, n, 0, lb, rb0);
      chk_op(o, r, c, n, lb, rb0);
    end

    // R9: busy longer than the watchdog limit
    busy_len = 400; wlim = 20'd60;
    run_op(2, 24'h000777, 0, 0, 0, lb, rb0);
    chk(tmo == 1'b1, "R9 timeout flagged", tmo, 1);
    chk(log_n - lb == 5, "R9 no status after timeout", log_n - lb, 5);
    @(negedge clk);
    chk(ce_no && !busy, "R9 chip released", {ce_no, busy}, 2'b10);
    repeat (500) @(negedge clk);
    busy_len = 20; wlim = 20'd5000;
    run_op(4, 0, 0, 0, 0, lb, rb0);
    chk(!tmo && rbuf[rb0] == (8'h40 | {7'd0, fail_m}), "R9 recovery after timeout", rbuf[rb0], 8'h40 | fail_m);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=hung exp=finished");
      end
    join_any
    checks = checks + we_chk + fe_chk + re_chk;
    errors = errors + we_err + fe_err + re_err;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule